// File: doc/BRIEF.md
# Filtered A12 Scanline Interrupt Counter

This block produces a once-per-scanline interrupt for a cartridge mapper. The only input it has about the video side is the level of PPU address line A12, sampled on every CPU M2 cycle. A12 toggles many times within one scanline. The block therefore counts a rising edge of A12 only when A12 has been low for a long run of M2 cycles before it. Each recognised scanline steps an 8-bit down counter. When that counter is at zero and receives one more scanline, it expires. On expiry it reloads itself from a latched reload register and, if interrupts are enabled, pulls the active-low IRQ line down.

The CPU controls the block through single-cycle write strobes. The strobe carries a 2-bit register select and a data byte, and every write happens in a cycle with A12 low. A restart write loads the counter at once and picks the counting source. The first scanline after a restart may use a shorter low run, provided enough of that run came before the write. The IRQ line can only be released by disabling interrupts. Enabling interrupts never releases a line that is already asserted.

Top module: `scan_irq_counter`

## Requirements
- R1: After synchronous reset, `irq_n` is 1, interrupts are disabled and scanline counting is selected.
- R2: A scanline is recognised on an M2 cycle that samples A12 high right after at least 17 consecutive A12-low samples. A low run of 16 followed by a high sample is not recognised.
- R3: On the edge that samples the qualifying A12-high cycle, `irq_n` does not yet change. An expiry caused by that scanline drives `irq_n` low on the next edge, whatever A12 does in that cycle.
- R4: A12-high samples after the first one in a high run add no scanlines.
- R5: Select code 1 (restart) with data bit 0 = 0 works as follows. If at least 4 A12-low samples came before the write cycle, the first scanline after the write needs only 13 consecutive low samples in total, with the write cycle's own sample included. With fewer than 4 before the write, the usual 17 applies.
- R6: Select code 0 stores the data as the reload value and leaves the running counter alone. A restart write loads the counter from the reload value. A scanline at count zero expires and reloads the counter. Any other scanline decrements it. The interrupt period is therefore reload+1 scanlines.
- R7: Without a reload write, the reload value after reset is 255. A restart followed by 256 scanlines gives the first expiry, and 255 scanlines do not.
- R8: Select code 3 enables interrupts and leaves an asserted `irq_n` low. Select code 2 disables interrupts and returns `irq_n` to 1.
- R9: An expiry drives `irq_n` low only when interrupts are enabled. The counter keeps stepping while interrupts are disabled and while `irq_n` is low.
- R10: A restart write with data bit 0 = 1 selects CPU-cycle mode. In that mode A12 scanlines do not step the counter, until a restart with bit 0 = 0 selects scanline mode again.
- R11: The A12-low run length saturates. A run of 40 or more low samples still qualifies the next high sample as a scanline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | M2 clock; all state moves on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ppu_a12 | input | 1 | PPU address line A12 level for this M2 cycle |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_sel | input | 2 | Register select: 0 reload, 1 restart/mode, 2 IRQ disable, 3 IRQ enable |
| wr_data | input | 8 | Write data byte |
| irq_n | output | 1 | Active-low interrupt request, registered |

## Verification
The bench probes the filter exactly at its thresholds: low runs of 16 and 17, and the relaxed first line with 3 and 4 low samples before the restart. A filter that is off by one there would lose lines or count A12 chatter. It drives a long high run, which a design that counts levels instead of edges would turn into several scanlines. It also drives a 40-cycle low run, which a wrapping filter would reject. Reload values are rewritten in the middle of a count, so a design that loads them at once would fire early. Interrupts are disabled in the middle of a count, so a design that stops counting while disabled would fire late. An enable write lands on an asserted line and must not release it. Random A12 patterns mixed with random writes are then checked cycle by cycle against a bench model.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;

  // CPU-visible register selects (decode of the write strobe)
  typedef enum logic [1:0] {
    SEL_RELOAD  = 2'd0,
    SEL_RESTART = 2'd1,
    SEL_IRQ_OFF = 2'd2,
    SEL_IRQ_ON  = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/a12_line_filter.sv
module a12_line_filter #(
  parameter int LOW_W     = 5,
  parameter int LINE_MIN  = 17,
  parameter int FIRST_MIN = 13,
  parameter int PRE_MIN   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic a12_i,
  input  logic restart_i,
  input  logic cycle_mode_i,
  output logic tick_o
);

  localparam logic [LOW_W-1:0] LOW_MAX = {LOW_W{1'b1}};
  localparam logic [LOW_W-1:0] LINE_T  = LOW_W'(LINE_MIN);
  localparam logic [LOW_W-1:0] FIRST_T = LOW_W'(FIRST_MIN);
  localparam logic [LOW_W-1:0] PRE_T   = LOW_W'(PRE_MIN);

  logic [LOW_W-1:0] low_cnt;
  logic             first_q;
  logic             scan_mode_q;
  logic             tick_q;
  logic [LOW_W-1:0] need;
  logic             line_hit;

  always_comb begin
    need     = first_q ? FIRST_T : LINE_T;
    line_hit = a12_i && scan_mode_q && (low_cnt >= need);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt     <= '0;
      first_q     <= 1'b0;
      scan_mode_q <= 1'b1;
      tick_q      <= 1'b0;
    end else begin
      tick_q <= line_hit;
      if (a12_i)
        low_cnt <= '0;
      else if (low_cnt != LOW_MAX)
        low_cnt <= low_cnt + 1'b1;
      if (restart_i) begin
        scan_mode_q <= !cycle_mode_i;
        first_q     <= !cycle_mode_i && !a12_i && (low_cnt >= PRE_T);
      end else if (a12_i) begin
        first_q <= 1'b0;
      end
    end
  end

  assign tick_o = tick_q;

  // R4: a high run yields one scanline at most, never two in a row
  a_r4_single_tick: assert property (@(posedge clk) disable iff (rst)
    tick_q |=> !tick_q);
  // R2: a scanline pulse always follows a sampled A12-high cycle
  a_r2_tick_after_high: assert property (@(posedge clk) disable iff (rst)
    tick_q |-> $past(a12_i));
  // R11: a low sample never wraps the run counter back to zero
  a_r11_no_wrap: assert property (@(posedge clk) disable iff (rst)
    !a12_i |=> (low_cnt != '0));

endmodule

// File: rtl/line_down_counter.sv
module line_down_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] data_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload_q;

  assign expire_o = tick_i && (cnt_q == '0) && !restart_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      reload_q <= '1;
    end else begin
      if (restart_i)
        cnt_q <= reload_q;
      else if (tick_i)
        cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - 1'b1;
      if (load_i)
        reload_q <= data_i;
    end
  end

  // R6: the count only moves on a scanline or a restart
  a_r6_count_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !restart_i) |=> $stable(cnt_q));
  // R6: the reload value only moves on its own write
  a_r6_reload_hold: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(reload_q));

endmodule

// File: rtl/irq_gate.sv
module irq_gate (
  input  logic clk,
  input  logic rst,
  input  logic expire_i,
  input  logic irq_off_i,
  input  logic irq_on_i,
  output logic irq_n
);

  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      irq_n <= 1'b1;
    end else if (irq_off_i) begin
      en_q  <= 1'b0;
      irq_n <= 1'b1;
    end else begin
      if (irq_on_i)
        en_q <= 1'b1;
      if (expire_i && en_q)
        irq_n <= 1'b0;
    end
  end

  // R8: enabling leaves an asserted line asserted
  a_r8_on_keeps: assert property (@(posedge clk) disable iff (rst)
    (irq_on_i && !irq_off_i && !irq_n) |=> !irq_n);
  // R8: disabling releases the line
  a_r8_off_clears: assert property (@(posedge clk) disable iff (rst)
    irq_off_i |=> irq_n);
  // R9: the line only falls while interrupts were enabled
  a_r9_gated: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> $past(en_q));

endmodule

// File: rtl/scan_irq_counter.sv
module scan_irq_counter #(
  parameter int DATA_W    = 8,
  parameter int LOW_W     = 5,
  parameter int LINE_MIN  = 17,
  parameter int FIRST_MIN = 13,
  parameter int PRE_MIN   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ppu_a12,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              irq_n
);
  import scan_irq_pkg::*;

  logic wr_reload, wr_restart, wr_off, wr_on;
  logic tick, expire;

  always_comb begin
    wr_reload  = wr_en && (reg_sel_e'(wr_sel) == SEL_RELOAD);
    wr_restart = wr_en && (reg_sel_e'(wr_sel) == SEL_RESTART);
    wr_off     = wr_en && (reg_sel_e'(wr_sel) == SEL_IRQ_OFF);
    wr_on      = wr_en && (reg_sel_e'(wr_sel) == SEL_IRQ_ON);
  end

  a12_line_filter #(
    .LOW_W(LOW_W), .LINE_MIN(LINE_MIN), .FIRST_MIN(FIRST_MIN), .PRE_MIN(PRE_MIN)
  ) u_filter (
    .clk(clk), .rst(rst), .a12_i(ppu_a12),
    .restart_i(wr_restart), .cycle_mode_i(wr_data[0]), .tick_o(tick)
  );

  line_down_counter #(.CNT_W(DATA_W)) u_count (
    .clk(clk), .rst(rst), .tick_i(tick), .restart_i(wr_restart),
    .load_i(wr_reload), .data_i(wr_data), .expire_o(expire)
  );

  irq_gate u_irq (
    .clk(clk), .rst(rst), .expire_i(expire),
    .irq_off_i(wr_off), .irq_on_i(wr_on), .irq_n(irq_n)
  );

endmodule

// File: tb/scan_irq_counter_test.sv
module scan_irq_counter_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ppu_a12 = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench reference state
  int m_low, m_cnt, m_rel;
  bit m_first, m_mode, m_tick, m_en, m_irq_n;

  scan_irq_counter uut (
    .clk(clk), .rst(rst), .ppu_a12(ppu_a12), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .irq_n(irq_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_low = 0; m_cnt = 0; m_rel = 255;
    m_first = 0; m_mode = 1; m_tick = 0; m_en = 0; m_irq_n = 1;
  endtask

  task automatic model_step(input bit a, input bit we, input int sel, input int d);
    int need;
    bit n_tick, rs, ex;
    need   = m_first ? 13 : 17;
    n_tick = m_mode && a && (m_low >= need);
    rs     = we && sel == 1;
    ex     = m_tick && m_cnt == 0 && !rs;
    if (rs) begin
      m_first = (d % 2 == 0) && !a && m_low >= 4;
      m_mode  = (d % 2 == 0);
    end else if (a) m_first = 0;
    m_low = a ? 0 : (m_low < 31 ? m_low + 1 : 31);
    if (rs) m_cnt = m_rel;
    else if (m_tick) m_cnt = (m_cnt == 0) ? m_rel : m_cnt - 1;
    if (we && sel == 0) m_rel = d;
    if (we && sel == 2) begin m_en = 0; m_irq_n = 1; end
    else begin
      if (ex && m_en) m_irq_n = 0;
      if (we && sel == 3) m_en = 1;
    end
    m_tick = n_tick;
  endtask

  task automatic step(input bit a, input bit we, input int sel, input int d);
    @(negedge clk);
    ppu_a12 = a; wr_en = we; wr_sel = 2'(sel); wr_data = 8'(d);
    model_step(a, we, sel, d);
    @(posedge clk);
    #1;
    chk(irq_n == m_irq_n, "model R2 R5 R6 R8 R9", irq_n, m_irq_n);
  endtask

  task automatic lows(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask
  task automatic highs(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0);
  endtask
  task automatic wr(input int sel, input int d);
    step(0, 1, sel, d);
  endtask
  task automatic line(input int n);
    lows(n); highs(1);
  endtask
  task automatic ack();
    wr(2, 0); wr(3, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1 chk(irq_n == 1'b1, "R1 reset irq_n", irq_n, 1);

    // R7: default reload of 255
    wr(3, 0); highs(1); wr(1, 0);
    for (int i = 0; i < 255; i++) line(17);
    lows(2);
    chk(irq_n == 1'b1, "R7 no expiry after 255 lines", irq_n, 1);
    line(17);
    chk(irq_n == 1'b1, "R3 unchanged on qualifying high edge", irq_n, 1);
    step(1, 0, 0, 0);
    chk(irq_n == 1'b0, "R3 R7 expiry one edge later, A12 high", irq_n, 0);
    wr(2, 0);
    chk(irq_n == 1'b1, "R8 disable releases", irq_n, 1);
    wr(3, 0);

    // R2: 16 vs 17 low samples
    wr(0, 0); highs(1); wr(1, 0); highs(1);
    line(16); step(0, 0, 0, 0);
    chk(irq_n == 1'b1, "R2 sixteen lows rejected", irq_n, 1);
    line(17); step(0, 0, 0, 0);
    chk(irq_n == 1'b0, "R2 seventeen lows accepted", irq_n, 0);
    wr(3, 0);
    chk(irq_n == 1'b0, "R8 enable keeps line low", irq_n, 0);
    ack();

    // R4: long high run counts once
    wr(0, 1); wr(1, 0); highs(1); lows(17); highs(5); lows(1);
    chk(irq_n == 1'b1, "R4 five highs count as one", irq_n, 1);
    line(17); step(0, 0, 0, 0);
    chk(irq_n == 1'b0, "R4 second line expires", irq_n, 0);
    ack();

    // R6: reload is latched until expiry
    wr(0, 2); wr(1, 0); highs(1); line(17);
    wr(0, 0); lows(16); highs(1); step(0, 0, 0, 0);
    chk(irq_n == 1'b1, "R6 mid-count reload ignored", irq_n, 1);
    lows(16); highs(1); step(0, 0, 0, 0);
    chk(irq_n == 1'b0, "R6 expiry after reload+1 lines", irq_n, 0);
    wr(2, 0); wr(3, 0); lows(15); highs(1); step(0, 0, 0, 0);
    chk(irq_n == 1'b0, "R6 new reload applied after expiry", irq_n, 0);
    ack();

    // R5: relaxed first line with 4 lows before restart
    highs(1); wr(0, 0); lows(3); wr(1, 0); lows(8); highs(1); step(0, 0, 0, 0);
    chk(irq_n == 1'b0, "R5 first line at 13 lows", irq_n, 0);
    ack();
    highs(1); wr(0, 0); lows(2); wr(1, 0); lows(10); highs(1); step(0, 0, 0, 0);
    chk(irq_n == 1'b1, "R5 only 3 lows before restart", irq_n, 1);
    line(17); step(0, 0, 0, 0);
    chk(irq_n == 1'b0, "R5 normal line after", irq_n, 0);
    ack();

    // R9: counting continues while disabled
    wr(0, 2); wr(1, 0); wr(2, 0); highs(1); line(17); line(17);
    wr(3, 0);
    chk(irq_n == 1'b1, "R9 no irq while disabled", irq_n, 1);
    lows(16); highs(1); step(0, 0, 0, 0);
    chk(irq_n == 1'b0, "R9 count advanced while disabled", irq_n, 0);
    ack();

    // R10: cycle mode stops scanline counting
    wr(0, 0); wr(1, 1); highs(1); line(17); step(0, 0, 0, 0);
    chk(irq_n == 1'b1, "R10 cycle mode ignores A12", irq_n, 1);
    wr(1, 0); highs(1); line(17); step(0, 0, 0, 0);
    chk(irq_n == 1'b0, "R10 scanline mode restored", irq_n, 0);
    ack();

    // R11: saturating low run
    highs(1); lows(40); highs(1); step(0, 0, 0, 0);
    chk(irq_n == 1'b0, "R11 forty lows still qualify", irq_n, 0);
    ack();

    // random mix against the reference model
    void'($urandom(32'h5ca1ab1e));
    for (int it = 0; it < 2500; it++) begin
      int nl, nh, wpos;
      nl   = 10 + int'($urandom_range(0, 12));
      if ($urandom_range(0, 15) == 0) nl = 30 + int'($urandom_range(0, 15));
      nh   = 1 + int'($urandom_range(0, 2));
      wpos = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, nl - 1)) : -1;
      for (int k = 0; k < nl; k++) begin
        if (k == wpos) begin
          int s, d;
          s = int'($urandom_range(0, 3));
          d = (s == 0) ? int'($urandom_range(0, 3))
            : (s == 1) ? (($urandom_range(0, 7) == 0) ? 1 : 0) : 0;
          wr(s, d);
        end else step(0, 0, 0, 0);
      end
      highs(nh);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule